// File: doc/BRIEF.md
# Fast Ethernet Transmit Coding Chain

This block turns the nibble stream a MAC presents on its transmit interface into the three-level symbol stream for a 100 Mb/s twisted-pair line. A single bit clock runs the block, and a one-cycle `sym_en` pulse marks every fifth cycle. On that pulse the block samples `txd`, `tx_en` and `tx_er`. It then picks a 5-bit code-group. It sends an idle group between frames and opens each frame with a start delimiter pair in place of the first two preamble nibbles. Data nibbles go out as table codes, a halt group replaces any nibble flagged with `tx_er`, and an end delimiter pair follows the last nibble.

Each code-group is shifted out one bit per cycle, least significant bit first. The scrambler is an 11-bit linear feedback shift register that runs freely and is XORed onto every bit. The result is converted to NRZI and then to a three-level MLT-3 waveform. The line level is reported as a two-bit code. Each of the four coding stages has its own bypass input, so a test setup or a non-standard medium can turn any of them off independently of the others.

Top module: `tx_pcs_encoder`

## Requirements
- R1: While the block is between frames and `tx_en` is low at a symbol enable, the code-group sent is idle, 11111 (value bits 4..0).
- R2: The first symbol enable with `tx_en` high after idle sends /J/ = 11000, and the next symbol enable sends /K/ = 10001. Both ignore `txd` and `tx_er`. Data follows from the third symbol onward.
- R3: In a frame, a nibble with `tx_er` low is sent as the code 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101.
- R4: The first symbol enable in the data phase with `tx_en` low sends /T/ = 01101, whatever `tx_er` is. The next symbol enable sends /R/ = 00111, even if `tx_en` is high again. After that the block is idle.
- R5: A data-phase symbol with both `tx_en` and `tx_er` high sends the invalid halt group 00100 in place of the nibble.
- R6: With `byp_4b5b` high, every symbol sends the raw group {`tx_er`, `txd`} and inserts no delimiters.
- R7: A code-group is loaded at the clock edge that samples `sym_en`. Its bit 0 drives the serial stream in the following cycle, and bits 1..4 follow one per cycle. The line level for a serial bit appears two clock edges after that bit was first presented.
- R8: The scrambler state resets to the nonzero `SEED` and advances every cycle as s <= {s[9:0], s[10]^s[8]}. Each serial bit is XORed with s[10] of the current state. With `byp_scr` high the XOR is skipped, but the state still advances.
- R9: The NRZI stage toggles its output on each scrambled 1 and holds it on each 0. With `byp_nrzi` high it passes the scrambled bit straight through.
- R10: The MLT-3 stage steps through the levels 0, +1, 0, -1 on each 1 from the NRZI stage and holds its level on each 0. Levels are coded 00 = 0, 01 = +1, 11 = -1. Code 10 never appears, and the level never jumps directly between +1 and -1.
- R11: With `byp_mlt` high, `line_lvl` is 00 for an NRZI 0 and 01 for an NRZI 1.
- R12: While `rst` is high, `line_lvl` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, five cycles per nibble |
| rst | input | 1 | Synchronous reset, active high |
| sym_en | input | 1 | One-cycle pulse every fifth cycle that samples the nibble inputs |
| txd | input | 4 | Transmit nibble |
| tx_en | input | 1 | Frame in progress |
| tx_er | input | 1 | Coding error request; fifth bit when 4B/5B is bypassed |
| byp_4b5b | input | 1 | Bypass nibble coding and delimiters |
| byp_scr | input | 1 | Bypass scrambling |
| byp_nrzi | input | 1 | Bypass NRZI conversion |
| byp_mlt | input | 1 | Bypass three-level coding |
| line_lvl | output | 2 | Line level: 00 zero, 01 plus, 11 minus |

## Verification
Two pairs of events can land on the same symbol. In the first, `tx_er` is still high on the symbol where `tx_en` falls, so the end delimiter and the halt group compete. In the second, `tx_er` is high on the symbol that opens a frame, so the start delimiter and the halt group compete. The stimulus forces both overlaps on purpose. In each case the bench expects the delimiter, /T/ or /J/, to win. It also re-opens a frame during the /R/ symbol and expects /R/ followed by idle. The scoreboard compares every line level against a model of the chain built from the requirements. Any wrong choice in these collisions therefore shows up as a level mismatch two edges after the affected bit.

// File: rtl/tx_pcs_pkg.sv
package tx_pcs_pkg;

    localparam int GRP_W  = 5;
    localparam int NIB_W  = 4;
    localparam int LFSR_W = 11;
    localparam int TAP_HI = LFSR_W - 1;   // x^11 term
    localparam int TAP_LO = 8;            // x^9 term

    typedef logic [GRP_W-1:0]  cgrp_t;
    typedef logic [LFSR_W-1:0] lfsr_t;

    localparam cgrp_t CG_IDLE = 5'b11111;
    localparam cgrp_t CG_J    = 5'b11000;
    localparam cgrp_t CG_K    = 5'b10001;
    localparam cgrp_t CG_T    = 5'b01101;
    localparam cgrp_t CG_R    = 5'b00111;
    localparam cgrp_t CG_HALT = 5'b00100;

    typedef enum logic [1:0] {
        FS_IDLE   = 2'd0,
        FS_SEND_K = 2'd1,
        FS_DATA   = 2'd2,
        FS_SEND_R = 2'd3
    } frm_st_e;

    typedef enum logic [1:0] {
        LVL_ZERO = 2'b00,
        LVL_POS  = 2'b01,
        LVL_NEG  = 2'b11
    } lvl_e;

    typedef struct packed {
        logic             en;
        logic             er;
        logic [NIB_W-1:0] d;
    } mii_tx_t;

    function automatic cgrp_t nib_to_cg(input logic [NIB_W-1:0] n);
        cgrp_t c;
        case (n)
            4'h0: c = 5'b11110;
            4'h1: c = 5'b01001;
            4'h2: c = 5'b10100;
            4'h3: c = 5'b10101;
            4'h4: c = 5'b01010;
            4'h5: c = 5'b01011;
            4'h6: c = 5'b01110;
            4'h7: c = 5'b01111;
            4'h8: c = 5'b10010;
            4'h9: c = 5'b10011;
            4'hA: c = 5'b10110;
            4'hB: c = 5'b10111;
            4'hC: c = 5'b11010;
            4'hD: c = 5'b11011;
            4'hE: c = 5'b11100;
            default: c = 5'b11101;
        endcase
        return c;
    endfunction

    function automatic lfsr_t lfsr_step(input lfsr_t s);
        return {s[LFSR_W-2:0], s[TAP_HI] ^ s[TAP_LO]};
    endfunction

    function automatic lvl_e phase_lvl(input logic [1:0] ph);
        lvl_e l;
        case (ph)
            2'd1:    l = LVL_POS;
            2'd3:    l = LVL_NEG;
            default: l = LVL_ZERO;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/tx_pcs_framer.sv
module tx_pcs_framer
    import tx_pcs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sym_en,
    input  logic    byp_4b5b,
    input  mii_tx_t mii,
    output cgrp_t   code,
    output frm_st_e st
);

    frm_st_e st_nxt;
    cgrp_t   framed;

    always_comb begin
        st_nxt = st;
        framed = CG_IDLE;
        case (st)
            FS_IDLE: begin
                if (mii.en) begin
                    framed = CG_J;
                    st_nxt = FS_SEND_K;
                end
            end
            FS_SEND_K: begin
                framed = CG_K;
                st_nxt = FS_DATA;
            end
            FS_DATA: begin
                if (mii.en) begin
                    framed = mii.er ? CG_HALT : nib_to_cg(mii.d);
                end else begin
                    framed = CG_T;
                    st_nxt = FS_SEND_R;
                end
            end
            default: begin
                framed = CG_R;
                st_nxt = FS_IDLE;
            end
        endcase
        code = byp_4b5b ? {mii.er, mii.d} : framed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= FS_IDLE;
        end else if (sym_en) begin
            st <= st_nxt;
        end
    end

endmodule

// File: rtl/tx_pcs_serializer.sv
module tx_pcs_serializer
    import tx_pcs_pkg::*;
#(
    parameter lfsr_t SEED = 11'h5A5
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sym_en,
    input  logic  byp_scr,
    input  cgrp_t code,
    output logic  raw_bit,
    output logic  scr_bit,
    output lfsr_t lfsr_q
);

    cgrp_t shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (sym_en) begin
            shreg <= code;
        end else begin
            shreg <= {1'b0, shreg[GRP_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr_q <= SEED;
        end else begin
            lfsr_q <= lfsr_step(lfsr_q);
        end
    end

    assign raw_bit = shreg[0];
    assign scr_bit = raw_bit ^ (~byp_scr & lfsr_q[TAP_HI]);

endmodule

// File: rtl/tx_pcs_line.sv
module tx_pcs_line
    import tx_pcs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    input  logic byp_nrzi,
    input  logic byp_mlt,
    output lvl_e lvl
);

    logic       nrzi_q;
    logic [1:0] phase_q;
    logic [1:0] phase_inc;

    assign phase_inc = phase_q + 2'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            nrzi_q <= 1'b0;
        end else if (byp_nrzi) begin
            nrzi_q <= bit_in;
        end else begin
            nrzi_q <= nrzi_q ^ bit_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 2'd0;
            lvl     <= LVL_ZERO;
        end else if (byp_mlt) begin
            lvl <= nrzi_q ? LVL_POS : LVL_ZERO;
        end else if (nrzi_q) begin
            phase_q <= phase_inc;
            lvl     <= phase_lvl(phase_inc);
        end else begin
            lvl <= phase_lvl(phase_q);
        end
    end

endmodule

// File: rtl/tx_pcs_encoder.sv
module tx_pcs_encoder
    import tx_pcs_pkg::*;
#(
    parameter logic [10:0] SEED = 11'h5A5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sym_en,
    input  logic [3:0] txd,
    input  logic       tx_en,
    input  logic       tx_er,
    input  logic       byp_4b5b,
    input  logic       byp_scr,
    input  logic       byp_nrzi,
    input  logic       byp_mlt,
    output logic [1:0] line_lvl
);

    mii_tx_t mii;
    cgrp_t   code;
    frm_st_e frm_st;
    logic    raw_bit;
    logic    scr_bit;
    lfsr_t   lfsr_q;
    lvl_e    lvl;

    assign mii = '{en: tx_en, er: tx_er, d: txd};

    tx_pcs_framer u_framer (
        .clk      (clk),
        .rst      (rst),
        .sym_en   (sym_en),
        .byp_4b5b (byp_4b5b),
        .mii      (mii),
        .code     (code),
        .st       (frm_st)
    );

    tx_pcs_serializer #(.SEED(SEED)) u_ser (
        .clk     (clk),
        .rst     (rst),
        .sym_en  (sym_en),
        .byp_scr (byp_scr),
        .code    (code),
        .raw_bit (raw_bit),
        .scr_bit (scr_bit),
        .lfsr_q  (lfsr_q)
    );

    tx_pcs_line u_line (
        .clk      (clk),
        .rst      (rst),
        .bit_in   (scr_bit),
        .byp_nrzi (byp_nrzi),
        .byp_mlt  (byp_mlt),
        .lvl      (lvl)
    );

    assign line_lvl = lvl;

endmodule

// File: rtl/tx_pcs_encoder_chk.sv
module tx_pcs_encoder_chk
    import tx_pcs_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        sym_en,
    input logic [3:0]  txd,
    input logic        tx_en,
    input logic        tx_er,
    input logic        byp_4b5b,
    input logic        byp_mlt,
    input logic [1:0]  line_lvl,
    input frm_st_e     frm_st,
    input logic        raw_bit,
    input logic [10:0] lfsr_q
);

    p_idle_bit_r1: assert property (@(posedge clk) disable iff (rst)
        (sym_en && frm_st == FS_IDLE && !tx_en && !byp_4b5b) |=> raw_bit);

    p_start_j_r2: assert property (@(posedge clk) disable iff (rst)
        (sym_en && frm_st == FS_IDLE && tx_en && !byp_4b5b) |=> (frm_st == FS_SEND_K && !raw_bit));

    p_end_t_r4: assert property (@(posedge clk) disable iff (rst)
        (sym_en && frm_st == FS_DATA && !tx_en && !byp_4b5b) |=> (frm_st == FS_SEND_R && raw_bit));

    p_halt_r5: assert property (@(posedge clk) disable iff (rst)
        (sym_en && frm_st == FS_DATA && tx_en && tx_er && !byp_4b5b) |=> !raw_bit);

    p_raw_group_r6: assert property (@(posedge clk) disable iff (rst)
        (sym_en && byp_4b5b) |=> (raw_bit == $past(txd[0])));

    p_state_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !sym_en |=> $stable(frm_st));

    p_lfsr_live_r8: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);

    p_lvl_legal_r10: assert property (@(posedge clk) disable iff (rst)
        line_lvl != 2'b10);

    p_no_jump_r10: assert property (@(posedge clk) disable iff (rst)
        (!byp_mlt && $past(!byp_mlt)) |->
        !((($past(line_lvl) == 2'b01) && (line_lvl == 2'b11)) ||
          (($past(line_lvl) == 2'b11) && (line_lvl == 2'b01))));

    p_two_level_r11: assert property (@(posedge clk) disable iff (rst)
        (byp_mlt && $past(byp_mlt)) |-> (line_lvl[1] == 1'b0));

endmodule

bind tx_pcs_encoder tx_pcs_encoder_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .sym_en   (sym_en),
    .txd      (txd),
    .tx_en    (tx_en),
    .tx_er    (tx_er),
    .byp_4b5b (byp_4b5b),
    .byp_mlt  (byp_mlt),
    .line_lvl (line_lvl),
    .frm_st   (frm_st),
    .raw_bit  (raw_bit),
    .lfsr_q   (lfsr_q)
);

// File: tb/tx_pcs_encoder_tb_top.sv
module tx_pcs_encoder_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam logic [10:0] SEED       = 11'h5A5;
    localparam int          WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_en = 1'b0;
    logic [3:0] txd = 4'h0;
    logic       tx_en = 1'b0;
    logic       tx_er = 1'b0;
    logic       b4 = 1'b0, bs = 1'b0, bn = 1'b0, bm = 1'b0;
    logic [1:0] line_lvl;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_pcs_encoder #(.SEED(SEED)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .sym_en   (sym_en),
        .txd      (txd),
        .tx_en    (tx_en),
        .tx_er    (tx_er),
        .byp_4b5b (b4),
        .byp_scr  (bs),
        .byp_nrzi (bn),
        .byp_mlt  (bm),
        .line_lvl (line_lvl)
    );

    typedef struct packed {
        logic       b;
        logic [3:0] tag;
    } exp_t;

    exp_t  q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 0;
    int    bst    = 0;
    string cfg    = "reset";

    logic [10:0] lfsr_m;
    logic        nrzi_m, s_prev;
    logic [1:0]  ph_m, out_m;
    logic [3:0]  t_s, t_n;
    bit          started;

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd1: return "R1 idle";
            4'd2: return "R2 start delimiter";
            4'd3: return "R3 data code";
            4'd4: return "R4 end delimiter";
            4'd5: return "R5 halt";
            4'd6: return "R6 raw group";
            default: return "R7 pre-load bits";
        endcase
    endfunction

    function automatic logic [4:0] code_of(input logic [3:0] n);
        logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                               5'b01010, 5'b01011, 5'b01110, 5'b01111,
                               5'b10010, 5'b10011, 5'b10110, 5'b10111,
                               5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return t[n];
    endfunction

    function automatic logic [10:0] next_lfsr(input logic [10:0] s);
        return {s[9:0], s[10] ^ s[8]};
    endfunction

    function automatic logic [1:0] lvl_of(input logic [1:0] p);
        return (p == 2'd1) ? 2'b01 : (p == 2'd3) ? 2'b11 : 2'b00;
    endfunction

    task automatic check(input logic [1:0] act, input logic [1:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s [%s]: line_lvl=%b expected=%b at %0t", req, cfg, act, exp, $time);
        end
    endtask

    task automatic send(input logic en, input logic er, input logic [3:0] d);
        logic [4:0] c;
        logic [3:0] tg;
        exp_t       e;
        @(negedge clk);
        tx_en = en; tx_er = er; txd = d; sym_en = 1'b1;
        if (b4) begin
            c = {er, d}; tg = 4'd6;
        end else begin
            case (bst)
                0: if (en) begin c = 5'b11000; tg = 4'd2; bst = 1; end
                   else    begin c = 5'b11111; tg = 4'd1; end
                1: begin c = 5'b10001; tg = 4'd2; bst = 2; end
                2: if (en) begin
                       c  = er ? 5'b00100 : code_of(d);
                       tg = er ? 4'd5 : 4'd3;
                   end else begin
                       c = 5'b01101; tg = 4'd4; bst = 3;
                   end
                default: begin c = 5'b00111; tg = 4'd4; bst = 0; end
            endcase
        end
        for (int i = 0; i < 5; i++) begin
            e.b = c[i]; e.tag = tg;
            q.push_back(e);
        end
        @(negedge clk);
        sym_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic start_run(input logic a4, input logic as, input logic an, input logic am,
                             input string c);
        @(negedge clk);
        rst = 1'b1; sym_en = 1'b0; tx_en = 1'b0; tx_er = 1'b0; txd = 4'h0;
        b4 = a4; bs = as; bn = an; bm = am; bst = 0;
        repeat (3) @(negedge clk);
        cfg = c;
        rst = 1'b0;
    endtask

    task automatic frame_pattern();
        repeat (4) send(1'b0, 1'b0, 4'h3);
        send(1'b1, 1'b1, 4'h5);             // opening symbol with tx_er: delimiter wins
        repeat (7) send(1'b1, 1'b0, 4'h5);
        send(1'b1, 1'b0, 4'hD);
        for (int i = 0; i < 16; i++) send(1'b1, 1'b0, 4'(i));
        send(1'b1, 1'b1, 4'h7);             // halt
        send(1'b1, 1'b0, 4'hA);
        send(1'b0, 1'b1, 4'h2);             // tx_en falls with tx_er high: /T/ wins
        send(1'b0, 1'b0, 4'h0);
        repeat (3) send(1'b0, 1'b0, 4'h0);
        send(1'b1, 1'b0, 4'h5);
        send(1'b1, 1'b0, 4'h5);
        send(1'b1, 1'b0, 4'h9);
        send(1'b0, 1'b0, 4'h0);
        send(1'b1, 1'b0, 4'h0);             // new frame requested during /R/
        repeat (5) send(1'b0, 1'b0, 4'h0);
    endtask

    // scoreboard monitor: samples one time unit after each rising edge
    always @(posedge clk) begin
        #1;
        if (rst) begin
            check(line_lvl, 2'b00, "R12 reset level");
            lfsr_m  = SEED;
            nrzi_m  = 1'b0;
            ph_m    = 2'd0;
            out_m   = 2'b00;
            s_prev  = bs ? 1'b0 : SEED[10];
            t_s     = 4'd7;
            t_n     = 4'd7;
            started = 0;
            q.delete();
        end else begin
            exp_t e;
            if (bm) begin
                out_m = {1'b0, nrzi_m};
            end else begin
                if (nrzi_m) ph_m = ph_m + 2'd1;
                out_m = lvl_of(ph_m);
            end
            check(line_lvl, out_m, tag_name(t_n));
            nrzi_m = bn ? s_prev : (nrzi_m ^ s_prev);
            t_n    = t_s;
            lfsr_m = next_lfsr(lfsr_m);
            if (q.size() > 0) begin
                e = q.pop_front();
                started = 1;
            end else begin
                e.b = 1'b0; e.tag = 4'd7;
                if (started) begin
                    n_chk++; n_fail++;
                    $display("FAIL R7 scoreboard empty: queue=0 expected>0 at %0t", $time);
                end
            end
            s_prev = e.b ^ (bs ? 1'b0 : lfsr_m[10]);
            t_s    = e.tag;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL R7 watchdog: cycles=%0d expected<%0d", WATCHDOG, WATCHDOG);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        start_run(1'b0, 1'b0, 1'b0, 1'b0, "R7 R8 R9 R10 full chain");
        frame_pattern();
        start_run(1'b0, 1'b1, 1'b0, 1'b0, "R8 scrambler bypass, R9 R10");
        frame_pattern();
        start_run(1'b0, 1'b0, 1'b1, 1'b0, "R9 NRZI bypass, R8 R10");
        frame_pattern();
        start_run(1'b0, 1'b0, 1'b0, 1'b1, "R11 three-level bypass, R8 R9");
        frame_pattern();
        start_run(1'b1, 1'b0, 1'b0, 1'b0, "R6 coding bypass, R8 R9 R10");
        frame_pattern();
        start_run(1'b1, 1'b1, 1'b1, 1'b1, "R6 R11 every stage bypassed");
        frame_pattern();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule